// File: doc/BRIEF.md
# Charge-Cell Word Memory Controller

This block models a small word-organised memory whose cells behave like stored charge, together with the controller that drives them through their control phases. A client presents an address along with either a write request and its data, or a read request. The controller accepts the request only when it is idle. It latches the address and data, then runs a fixed series of phases. A write first drains the addressed word and then sets the ones of the new value into it. A read first raises a read-drive phase, then adds a sense phase. At the end of the sense phase the selected word is copied into a dedicated read-data register. That register stays on the output bus until the client releases the read.

The lowest address has no storage. It returns the live state of a set of external switch inputs, and writes to it change nothing. Sensing a word puts its ones back into the cell. When retention modelling is enabled, each stored word ages while nothing touches it. A word left alone for a configurable number of cycles drains to zero, so a periodic read works as a refresh. The read-data register is private to this block. Memory data can therefore be combined with any other register of the surrounding datapath.

Top module: `chargemem_ctrl`

## Requirements
- R1: After synchronous reset, busy, all three phase outputs, bus_drive and bus_data are 0, and every stored word reads back as 0.
- R2: An accepted write request runs an erase phase of PHASE_CYCLES cycles (ph_rd_en=1, ph_rd_drive=0) and then a write phase of PHASE_CYCLES cycles (ph_wr_en=1). Afterwards the word holds exactly the new data, whatever it held before.
- R3: An accepted read request runs PHASE_CYCLES cycles with only ph_rd_drive=1, then PHASE_CYCLES cycles with ph_rd_drive=1 and ph_rd_en=1. bus_drive=1 follows, with bus_data equal to the word sensed at the last edge of the sense phase. The bus holds that value until rd_release is sampled high.
- R4: Whenever bus_drive is 0, bus_data is 0. Within one cycle after rd_release is sampled, the bus is released and busy returns to 0.
- R5: Address 0 returns the switches inputs as they stand at the sense edge. A write to address 0 has no effect on any word.
- R6: ph_wr_en and ph_rd_en are never 1 in the same cycle.
- R7: Requests that arrive while busy=1 are ignored. When wr_req and rd_req are both high in an idle cycle, the write is taken.
- R8: A stored word that no write or read touches for RETAIN_CYCLES clock edges after its last touch is cleared to 0.
- R9: The sense edge of a read restores the word and restarts its retention count. If that edge is the very edge on which the word would expire, the word keeps its value.
- R10: The 3-bit address is decoded through a 2/4/8-line tree to exactly one word. Writing one address leaves every other word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | input | ABITS | Word address, latched on acceptance |
| wr_req | input | 1 | Write request |
| wr_data | input | WIDTH | Write data, latched on acceptance |
| rd_req | input | 1 | Read request |
| rd_release | input | 1 | Ends a read and frees the bus |
| switches | input | WIDTH | External inputs returned at address 0 |
| busy | output | 1 | A sequence is in progress |
| ph_rd_drive | output | 1 | Read-drive phase active |
| ph_rd_en | output | 1 | Read-enable (erase or sense) phase active |
| ph_wr_en | output | 1 | Write-enable phase active |
| bus_drive | output | 1 | Read-data register is on the bus |
| bus_data | output | WIDTH | Bus value, 0 when not driven |

## Verification
On a single word, the retention expiry and the restore done by a read's sense edge can land on the same clock edge. The bench sets this up by waiting a computed number of cycles after a write completes, so that the sense edge coincides with the expiry edge. It then expects the data to survive. It repeats the run one cycle later and expects a cleared word, which fixes the boundary from both sides. In a second collision, requests arrive in the middle of a write and a write and a read are requested together. The phase outputs and the words read back afterwards decide which of them was taken.

// File: rtl/chargemem_pkg.sv
package chargemem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE,
        ST_WRITE,
        ST_RPRE,
        ST_RSENSE,
        ST_HOLD
    } cm_state_e;

    typedef struct packed {
        logic rd_drive;
        logic rd_en;
        logic wr_en;
    } cm_phase_t;

    typedef struct packed {
        logic erase_done;
        logic write_done;
        logic sense_done;
    } cm_event_t;

    function automatic cm_phase_t phase_of(cm_state_e s);
        cm_phase_t p;
        p = '0;
        unique case (s)
            ST_ERASE:  p.rd_en = 1'b1;
            ST_WRITE:  p.wr_en = 1'b1;
            ST_RPRE:   p.rd_drive = 1'b1;
            ST_RSENSE: begin
                p.rd_drive = 1'b1;
                p.rd_en    = 1'b1;
            end
            ST_HOLD:   p.rd_drive = 1'b1;
            default:   p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cm_addr_tree.sv
module cm_addr_tree #(
    parameter int ABITS = 3
) (
    input  logic [ABITS-1:0]      addr,
    output logic [(1<<ABITS)-1:0] sel
);
    // Level l resolves the top l+1 address bits into 2^(l+1) lines.
    for (genvar l = 0; l < ABITS; l++) begin : g_lvl
        localparam int N = 2 << l;
        logic [N-1:0] line;
        for (genvar i = 0; i < N; i++) begin : g_line
            if (l == 0) begin : g_root
                assign line[i] = (addr[ABITS-1] == 1'(i % 2));
            end else begin : g_branch
                assign line[i] = g_lvl[l-1].line[i/2] & (addr[ABITS-1-l] == 1'(i % 2));
            end
        end
    end

    assign sel = g_lvl[ABITS-1].line;

endmodule

// File: rtl/cm_sequencer.sv
module cm_sequencer
    import chargemem_pkg::*;
#(
    parameter int PHASE_CYCLES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_wr,
    input  logic      start_rd,
    input  logic      rd_release,
    output cm_state_e state,
    output cm_event_t ev
);
    localparam int CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;

    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == CW'(PHASE_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start_wr)      state <= ST_ERASE;
                    else if (start_rd) state <= ST_RPRE;
                end
                ST_ERASE, ST_WRITE, ST_RPRE, ST_RSENSE: begin
                    if (last) begin
                        cnt <= '0;
                        unique case (state)
                            ST_ERASE:  state <= ST_WRITE;
                            ST_WRITE:  state <= ST_IDLE;
                            ST_RPRE:   state <= ST_RSENSE;
                            default:   state <= ST_HOLD;
                        endcase
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (rd_release) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ev.erase_done = (state == ST_ERASE)  && last;
        ev.write_done = (state == ST_WRITE)  && last;
        ev.sense_done = (state == ST_RSENSE) && last;
    end

endmodule

// File: rtl/cm_cell_array.sv
module cm_cell_array
    import chargemem_pkg::*;
#(
    parameter int WIDTH         = 8,
    parameter int WORDS         = 8,
    parameter bit RETAIN_EN     = 1'b1,
    parameter int RETAIN_CYCLES = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WORDS-1:0] sel,
    input  cm_event_t        ev,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] switches,
    output logic [WIDTH-1:0] rd_word
);
    localparam int RCW = $clog2(RETAIN_CYCLES + 1);

    logic [WIDTH-1:0] cell_q [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        if (i == 0) begin : g_sw
            assign cell_q[i] = switches;
        end else begin : g_cap
            logic [WIDTH-1:0] charge;
            logic             touch;
            logic             expire;

            assign touch = sel[i] & (ev.erase_done | ev.write_done | ev.sense_done);

            if (RETAIN_EN) begin : g_ret
                logic [RCW-1:0] age;
                assign expire = !touch && (age == RCW'(RETAIN_CYCLES - 1));
                always_ff @(posedge clk) begin
                    if (rst)                 age <= '0;
                    else if (touch || expire) age <= '0;
                    else                     age <= age + 1'b1;
                end
            end else begin : g_noret
                assign expire = 1'b0;
            end

            // Sensing rewrites the ones it finds, so the value is simply kept.
            always_ff @(posedge clk) begin
                if (rst)                            charge <= '0;
                else if (sel[i] && ev.erase_done)   charge <= '0;
                else if (sel[i] && ev.write_done)   charge <= charge | wr_data;
                else if (expire)                    charge <= '0;
            end

            assign cell_q[i] = charge;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (sel[k]) rd_word = rd_word | cell_q[k];
        end
    end

endmodule

// File: rtl/chargemem_ctrl.sv
module chargemem_ctrl
    import chargemem_pkg::*;
#(
    parameter int WIDTH         = 8,
    parameter int ABITS         = 3,
    parameter int PHASE_CYCLES  = 2,
    parameter bit RETAIN_EN     = 1'b1,
    parameter int RETAIN_CYCLES = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ABITS-1:0] req_addr,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_req,
    input  logic             rd_release,
    input  logic [WIDTH-1:0] switches,
    output logic             busy,
    output logic             ph_rd_drive,
    output logic             ph_rd_en,
    output logic             ph_wr_en,
    output logic             bus_drive,
    output logic [WIDTH-1:0] bus_data
);
    localparam int WORDS = 1 << ABITS;

    cm_state_e        state;
    cm_event_t        ev;
    cm_phase_t        phase;
    logic [ABITS-1:0] addr_q;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] rd_reg;
    logic [WIDTH-1:0] rd_word;
    logic [WORDS-1:0] sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (state == ST_IDLE && (wr_req || rd_req)) begin
            addr_q <= req_addr;
            data_q <= wr_data;
        end
    end

    cm_sequencer #(.PHASE_CYCLES(PHASE_CYCLES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_wr   (wr_req),
        .start_rd   (rd_req),
        .rd_release (rd_release),
        .state      (state),
        .ev         (ev)
    );

    cm_addr_tree #(.ABITS(ABITS)) u_dec (
        .addr (addr_q),
        .sel  (sel)
    );

    cm_cell_array #(
        .WIDTH         (WIDTH),
        .WORDS         (WORDS),
        .RETAIN_EN     (RETAIN_EN),
        .RETAIN_CYCLES (RETAIN_CYCLES)
    ) u_cells (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .ev       (ev),
        .wr_data  (data_q),
        .switches (switches),
        .rd_word  (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst)                rd_reg <= '0;
        else if (ev.sense_done) rd_reg <= rd_word;
    end

    assign phase       = phase_of(state);
    assign ph_rd_drive = phase.rd_drive;
    assign ph_rd_en    = phase.rd_en;
    assign ph_wr_en    = phase.wr_en;
    assign busy        = (state != ST_IDLE);
    assign bus_drive   = (state == ST_HOLD);
    assign bus_data    = bus_drive ? rd_reg : '0;

endmodule

module chargemem_ctrl_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             ph_rd_drive,
    input logic             ph_rd_en,
    input logic             ph_wr_en,
    input logic             bus_drive,
    input logic [WIDTH-1:0] bus_data
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: the cycle after reset everything is idle
    always @(posedge clk) begin
        if (rst_q && !rst) begin
            a_r1_reset_idle: assert (!busy && !bus_drive && bus_data == '0 &&
                                     !ph_rd_drive && !ph_rd_en && !ph_wr_en);
        end
    end

    a_r6_no_wr_rden_overlap: assert property (@(posedge clk) disable iff (rst)
        !(ph_wr_en && ph_rd_en));

    a_r4_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        !bus_drive |-> bus_data == '0);

    a_r3_bus_under_drive: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> ph_rd_drive);

    a_r3_bus_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (bus_drive && $past(bus_drive)) |-> $stable(bus_data));

    a_r2_write_after_erase: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_wr_en) |-> ($past(ph_rd_en) && !$past(ph_rd_drive)));

    a_r7_phase_means_busy: assert property (@(posedge clk) disable iff (rst)
        (ph_wr_en || ph_rd_en || ph_rd_drive) |-> busy);

endmodule

bind chargemem_ctrl chargemem_ctrl_checker #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .ph_rd_drive (ph_rd_drive),
    .ph_rd_en    (ph_rd_en),
    .ph_wr_en    (ph_wr_en),
    .bus_drive   (bus_drive),
    .bus_data    (bus_data)
);

// File: tb/chargemem_ctrl_test.sv
module chargemem_ctrl_test;
    localparam int PH  = 2;
    localparam int RET = 40;
    localparam int GAP = RET - 1 - 2*PH;   // read delay whose sense edge meets expiry

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] req_addr = '0;
    logic       wr_req = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_req = 1'b0;
    logic       rd_release = 1'b0;
    logic [7:0] switches = '0;
    logic       busy, ph_rd_drive, ph_rd_en, ph_wr_en, bus_drive;
    logic [7:0] bus_data;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    chargemem_ctrl #(.PHASE_CYCLES(PH), .RETAIN_CYCLES(RET)) uut (
        .clk(clk), .rst(rst), .req_addr(req_addr), .wr_req(wr_req),
        .wr_data(wr_data), .rd_req(rd_req), .rd_release(rd_release),
        .switches(switches), .busy(busy), .ph_rd_drive(ph_rd_drive),
        .ph_rd_en(ph_rd_en), .ph_wr_en(ph_wr_en), .bus_drive(bus_drive),
        .bus_data(bus_data)
    );

    // {addr, write data, switches, expected read}
    localparam int NV = 9;
    localparam logic [26:0] VEC [NV] = '{
        {3'd1, 8'h3C, 8'h00, 8'h3C},
        {3'd7, 8'hFF, 8'h00, 8'hFF},
        {3'd7, 8'h0F, 8'h00, 8'h0F},
        {3'd2, 8'h00, 8'h00, 8'h00},
        {3'd0, 8'h77, 8'h5A, 8'h5A},
        {3'd5, 8'h81, 8'h00, 8'h81},
        {3'd6, 8'h55, 8'h00, 8'h55},
        {3'd0, 8'h00, 8'hC3, 8'hC3},
        {3'd3, 8'hA5, 8'h00, 8'hA5}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        req_addr = a; wr_data = d; wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        chk(ph_rd_en && !ph_rd_drive && !ph_wr_en, "R2 erase phase",
            {ph_rd_drive, ph_rd_en, ph_wr_en}, 3'b010);
        repeat (PH) @(negedge clk);
        chk(ph_wr_en && !ph_rd_en, "R2/R6 write phase",
            {ph_rd_drive, ph_rd_en, ph_wr_en}, 3'b001);
        repeat (PH) @(negedge clk);
        chk(!busy, "R2 write done", busy, 0);
    endtask

    task automatic do_read(input logic [2:0] a, output logic [7:0] v);
        req_addr = a; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk(ph_rd_drive && !ph_rd_en, "R3 drive phase",
            {ph_rd_drive, ph_rd_en, ph_wr_en}, 3'b100);
        repeat (PH) @(negedge clk);
        chk(ph_rd_drive && ph_rd_en, "R3 sense phase",
            {ph_rd_drive, ph_rd_en, ph_wr_en}, 3'b110);
        repeat (PH) @(negedge clk);
        chk(bus_drive, "R3 bus driven", bus_drive, 1);
        v = bus_data;
        @(negedge clk);
        chk(bus_drive && bus_data == v, "R3 bus held", bus_data, v);
        rd_release = 1'b1;
        @(negedge clk);
        rd_release = 1'b0;
        chk(!bus_drive && bus_data == 8'h00 && !busy, "R4 bus released",
            {bus_drive, busy, bus_data}, 0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!busy && !bus_drive && bus_data == 0 && !ph_rd_drive && !ph_rd_en && !ph_wr_en,
            "R1 reset outputs", {busy, bus_drive, ph_rd_drive, ph_rd_en, ph_wr_en, bus_data}, 0);
        do_read(3'd4, v);
        chk(v == 8'h00, "R1 word reset", v, 8'h00);

        // Table: write then read back each entry
        for (int n = 0; n < NV; n++) begin
            switches = VEC[n][15:8];
            do_write(VEC[n][26:24], VEC[n][23:16]);
            do_read(VEC[n][26:24], v);
            chk(v == VEC[n][7:0], "R2/R5 table readback", v, VEC[n][7:0]);
        end

        // R10: neighbours untouched
        do_write(3'd3, 8'h5A);
        do_write(3'd4, 8'hA5);
        do_read(3'd3, v);
        chk(v == 8'h5A, "R10 neighbour kept", v, 8'h5A);

        // R5: write to address 0 leaves stored words alone
        do_write(3'd1, 8'h96);
        switches = 8'h24;
        do_write(3'd0, 8'hFF);
        do_read(3'd1, v);
        chk(v == 8'h96, "R5 addr0 write no effect", v, 8'h96);
        do_read(3'd0, v);
        chk(v == 8'h24, "R5 switches returned", v, 8'h24);

        // R7: simultaneous requests, write wins; requests while busy ignored
        repeat (RET + 5) @(negedge clk);
        req_addr = 3'd2; wr_data = 8'h99; wr_req = 1'b1; rd_req = 1'b1;
        @(negedge clk);
        chk(ph_rd_en && !ph_rd_drive, "R7 write priority",
            {ph_rd_drive, ph_rd_en, ph_wr_en}, 3'b010);
        req_addr = 3'd3; wr_data = 8'h11;
        repeat (2*PH - 1) @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0;
        @(negedge clk);
        chk(!busy, "R7 no request taken while busy", busy, 0);
        do_read(3'd2, v);
        chk(v == 8'h99, "R7 first write kept", v, 8'h99);
        do_read(3'd3, v);
        chk(v == 8'h00, "R7 busy write ignored", v, 8'h00);

        // R8: untouched word decays
        do_write(3'd4, 8'h6E);
        repeat (RET + 20) @(negedge clk);
        do_read(3'd4, v);
        chk(v == 8'h00, "R8 decay to zero", v, 8'h00);

        // R9: sense edge coincides with expiry edge -> survives
        do_write(3'd5, 8'hB7);
        repeat (GAP) @(negedge clk);
        do_read(3'd5, v);
        chk(v == 8'hB7, "R9 restore at expiry edge", v, 8'hB7);

        // R8: one cycle later the word is already gone
        do_write(3'd6, 8'h3D);
        repeat (GAP + 1) @(negedge clk);
        do_read(3'd6, v);
        chk(v == 8'h00, "R8 expiry one edge before sense", v, 8'h00);

        // R9: periodic reads refresh a word well past the retention time
        do_write(3'd1, 8'hC6);
        for (int k = 0; k < 4; k++) begin
            repeat (20) @(negedge clk);
            do_read(3'd1, v);
        end
        chk(v == 8'hC6, "R9 refresh by reads", v, 8'hC6);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule